// File: doc/BRIEF.md
# Configuration Space Unlock Controller

This block guards a small configuration register space behind a host I/O port. A host on a plain address/data bus with separate write and read strobes must first write an unlock key to a key port. Once unlocked, an index port selects an internal register and a data port reads or writes it. A fixed exit code written to the index port locks the space again.

Two stored bits decide how the key looks. The port-select bit is loaded from a strap pin at reset and lives in bit 0 of register 0x16. The key-select bit is bit 5 of register 0x0C. With the port-select bit at 0, one write to the low base port unlocks. With it at 1, two back-to-back matching writes to the high base port are needed. The key-select bit adds one to the key value. Register 0x0C also drives the mode pins of two serial ports: a fast-clock choice for each, a serial/infrared choice for the second, and line inversion for the second port's receive and transmit paths.

Top module: `cfgport_unlock`

## Requirements
- R1: After reset the space is locked, register 0x0C holds 0x28, and register 0x16 bit 0 equals the strap input. So uarta_fast=0, uartb_fast=0, uartb_normal=1, and both inverts are 0.
- R2: With register 0x16 bit 0 at 0, one write to 0x250 unlocks from the next cycle. The key is 0x88 when register 0x0C bit 5 is 0 and 0x89 when it is 1. Any other value leaves the space locked.
- R3: With register 0x16 bit 0 at 1, two writes of the key to 0x3F0 unlock. The key is 0x86 when register 0x0C bit 5 is 0 and 0x87 when it is 1. A non-key write to 0x3F0 between the two restarts the count. Writes to other addresses do not affect the count.
- R4: While unlocked with the low base, the index port is 0x251 and the data port is 0x252. With the high base, the index port is 0x3F0 and the data port is 0x3F1.
- R5: Register 0x0C drives the serial-port pins as follows. Bit 7 drives uarta_fast and bit 6 drives uartb_fast (1 = undivided clock, 0 = divided by 13). Bit 3 drives uartb_normal (1 = serial, 0 = infrared). Bit 1 drives uartb_rx_inv and bit 0 drives uartb_tx_inv.
- R6: Bits 4 and 2 of register 0x0C read 0 and ignore writes.
- R7: While unlocked, a write of 0xAA to the index port locks the space from the next cycle. The index register keeps its previous value.
- R8: While locked, data-port reads return 0xFF and data-port writes change nothing. A cycle with bus_rd low, or a read of an address that is neither the index port nor the data port, also returns 0xFF.
- R9: Register 0x16 bit 0 is writable through the data port, and a change moves the key, index and data ports at once. Key progress is cleared on every unlock and on every change of that bit.
- R10: Data writes under any index other than 0x0C and 0x16 change nothing, and those indexes read 0x00.
- R11: When the data port is written and read in the same cycle, the read returns the value held before the write. The new value is visible from the next cycle.
- R12: While unlocked, a read of the index port returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Reset value of register 0x16 bit 0 |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| unlocked | output | 1 | Configuration space is open |
| uarta_fast | output | 1 | First serial port takes the undivided clock |
| uartb_fast | output | 1 | Second serial port takes the undivided clock |
| uartb_normal | output | 1 | Second serial port in serial mode (0 = infrared) |
| uartb_rx_inv | output | 1 | Invert the second port's receive input |
| uartb_tx_inv | output | 1 | Invert the second port's transmit output |

## Verification
A data-port write and a data-port read of the same register can land in one cycle. The bench raises both strobes together on register 0x0C. It expects the old contents on bus_rdata in that cycle and the new contents on a read one cycle later. A write to register 0x16 bit 0 also moves the ports in the same clock. So the bench reads back through the moved data port at once, and tests that the old key port is dead while the new one takes the two-write key.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam logic [7:0] IDX_MODE   = 8'h0C;
   localparam logic [7:0] IDX_SEL    = 8'h16;
   localparam logic [7:0] MODE_RST   = 8'h28;
   localparam logic [7:0] MODE_RSVD  = 8'h14;
   localparam logic [7:0] EXIT_CODE  = 8'hAA;
   localparam logic [7:0] IDLE_DATA  = 8'hFF;

   typedef struct packed {
      logic uarta_fast;
      logic uartb_fast;
      logic key_sel;
      logic rsvd4;
      logic uartb_normal;
      logic rsvd2;
      logic rx_inv;
      logic tx_inv;
   } mode_reg_t;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned BASE_LO     = 16'h250,
   parameter int unsigned BASE_HI     = 16'h3F0,
   parameter logic [7:0]  KEY_LO      = 8'h88,
   parameter logic [7:0]  KEY_HI      = 8'h86,
   parameter int unsigned KEY_REPS_HI = 2,
   localparam int unsigned CW         = $clog2(KEY_REPS_HI + 1)
) (
   input  logic              alt,
   input  logic              key_sel,
   output logic [ADDR_W-1:0] key_port,
   output logic [ADDR_W-1:0] idx_port,
   output logic [ADDR_W-1:0] dat_port,
   output logic [7:0]        key_val,
   output logic [CW-1:0]     reps_need
);
   always_comb begin
      key_port  = alt ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
      idx_port  = alt ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO + 1);
      dat_port  = idx_port + ADDR_W'(1);
      key_val   = (alt ? KEY_HI : KEY_LO) + {7'd0, key_sel};
      reps_need = alt ? CW'(KEY_REPS_HI) : CW'(1);
   end
endmodule

// File: rtl/cfgport_keydet.sv
module cfgport_keydet
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned KEY_REPS_HI = 2,
   localparam int unsigned CW         = $clog2(KEY_REPS_HI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] key_port,
   input  logic [ADDR_W-1:0] idx_port,
   input  logic [7:0]        key_val,
   input  logic [CW-1:0]     reps_need,
   output logic              unlocked
);
   logic [CW-1:0] hits;
   logic          alt_q;
   logic          key_wr, exit_wr;

   assign key_wr  = !unlocked && wr_en && (addr == key_port);
   assign exit_wr = unlocked && wr_en && (addr == idx_port) && (wdata == EXIT_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         hits     <= '0;
         alt_q    <= alt;
      end else begin
         alt_q <= alt;
         if (key_wr) begin
            if (wdata == key_val) begin
               if ((hits + CW'(1)) >= reps_need) begin
                  unlocked <= 1'b1;
                  hits     <= '0;
               end else begin
                  hits <= hits + CW'(1);
               end
            end else begin
               hits <= '0;
            end
         end else if (exit_wr) begin
            unlocked <= 1'b0;
         end
         if (alt != alt_q) hits <= '0;
      end
   end

   // R2: an unlock is always caused by a key write to the key port
   assert_unlock_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en) && ($past(addr) == $past(key_port))
                          && ($past(wdata) == $past(key_val)));

   // R3: with the high base, the key must already have been seen once
   assert_dual_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(unlocked) && $past(alt)) |-> ($past(hits) == CW'(KEY_REPS_HI - 1)));

   // R7: the exit code locks the space
   assert_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exit_wr |=> !unlocked);
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic              unlocked,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] idx_port,
   input  logic [ADDR_W-1:0] dat_port,
   output mode_reg_t         mode,
   output logic              alt,
   output logic [7:0]        rd_val
);
   logic [7:0] idx;
   logic       idx_wr, dat_wr;

   assign idx_wr = unlocked && wr_en && (addr == idx_port) && (wdata != EXIT_CODE);
   assign dat_wr = unlocked && wr_en && (addr == dat_port);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= 8'h00;
         mode <= mode_reg_t'(MODE_RST);
         alt  <= strap_alt;
      end else begin
         if (idx_wr) idx <= wdata;
         if (dat_wr) begin
            case (idx)
               IDX_MODE: mode <= mode_reg_t'(wdata & ~MODE_RSVD);
               IDX_SEL:  alt  <= wdata[0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_val = IDLE_DATA;
      if (addr == dat_port) begin
         if (unlocked) begin
            case (idx)
               IDX_MODE: rd_val = mode;
               IDX_SEL:  rd_val = {7'd0, alt};
               default:  rd_val = 8'h00;
            endcase
         end
      end else if (unlocked && (addr == idx_port)) begin
         rd_val = idx;
      end
   end

   // R8: a locked space keeps its registers
   assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && wr_en) |=> ($stable(mode) && $stable(alt)));

   // R10: unimplemented indexes take no writes
   assert_other_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && (idx != IDX_MODE) && (idx != IDX_SEL)) |=> ($stable(mode) && $stable(alt)));

   // R6: reserved bits stay clear
   assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.rsvd4 == 1'b0) && (mode.rsvd2 == 1'b0));
endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned BASE_LO     = 16'h250,
   parameter int unsigned BASE_HI     = 16'h3F0,
   parameter logic [7:0]  KEY_LO      = 8'h88,
   parameter logic [7:0]  KEY_HI      = 8'h86,
   parameter int unsigned KEY_REPS_HI = 2,
   parameter bit          RD_PIPE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   output logic              unlocked,
   output logic              uarta_fast,
   output logic              uartb_fast,
   output logic              uartb_normal,
   output logic              uartb_rx_inv,
   output logic              uartb_tx_inv
);
   localparam int unsigned CW = $clog2(KEY_REPS_HI + 1);

   if (ADDR_W < 10 || ADDR_W > 32) begin : g_bad_width
      $error("cfgport_unlock: ADDR_W out of range");
   end
   if (KEY_REPS_HI < 1) begin : g_bad_reps
      $error("cfgport_unlock: KEY_REPS_HI must be at least 1");
   end
   if ((BASE_HI + 1) >= (64'd1 << ADDR_W) || (BASE_LO + 2) >= (64'd1 << ADDR_W)) begin : g_bad_base
      $error("cfgport_unlock: base ports do not fit ADDR_W");
   end

   mode_reg_t         mode;
   logic              alt;
   logic [ADDR_W-1:0] key_port, idx_port, dat_port;
   logic [7:0]        key_val, rd_val;
   logic [CW-1:0]     reps_need;

   cfgport_decode #(
      .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
      .KEY_LO(KEY_LO), .KEY_HI(KEY_HI), .KEY_REPS_HI(KEY_REPS_HI)
   ) u_decode (
      .alt(alt), .key_sel(mode.key_sel), .key_port(key_port), .idx_port(idx_port),
      .dat_port(dat_port), .key_val(key_val), .reps_need(reps_need)
   );

   cfgport_keydet #(.ADDR_W(ADDR_W), .KEY_REPS_HI(KEY_REPS_HI)) u_keydet (
      .clk(clk), .rst_n(rst_n), .alt(alt), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .key_port(key_port), .idx_port(idx_port),
      .key_val(key_val), .reps_need(reps_need), .unlocked(unlocked)
   );

   cfgport_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .unlocked(unlocked),
      .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .idx_port(idx_port),
      .dat_port(dat_port), .mode(mode), .alt(alt), .rd_val(rd_val)
   );

   assign uarta_fast   = mode.uarta_fast;
   assign uartb_fast   = mode.uartb_fast;
   assign uartb_normal = mode.uartb_normal;
   assign uartb_rx_inv = mode.rx_inv;
   assign uartb_tx_inv = mode.tx_inv;

   if (RD_PIPE) begin : g_rd_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= IDLE_DATA;
         else        rdata_q <= bus_rd ? rd_val : IDLE_DATA;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_val : IDLE_DATA;

      // R8: locked data-port reads float high
      assert_locked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !unlocked && (bus_addr == dat_port)) |-> (bus_rdata == IDLE_DATA));
   end
endmodule

// File: tb/cfgport_unlock_test.sv
module cfgport_unlock_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic        unlocked, uarta_fast, uartb_fast, uartb_normal, uartb_rx_inv, uartb_tx_inv;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cfgport_unlock uut (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .unlocked(unlocked), .uarta_fast(uarta_fast), .uartb_fast(uartb_fast),
      .uartb_normal(uartb_normal), .uartb_rx_inv(uartb_rx_inv), .uartb_tx_inv(uartb_tx_inv)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 check(tag, bus_rdata, exp);
      bus_rd = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 locked", unlocked, 0);
      check("R1 pins", {uarta_fast, uartb_fast, uartb_normal, uartb_rx_inv, uartb_tx_inv}, 5'b00100);
      rd(16'h252, 8'hFF, "R8 locked read");
      rd(16'h300, 8'hFF, "R8 stray read");
   endtask

   task automatic t_low_key;
      wr(16'h250, 8'h88);
      check("R2 wrong key", unlocked, 0);
      wr(16'h250, 8'h89);
      check("R2 key 0x89", unlocked, 1);
      wr(16'h251, 8'h0C);
      rd(16'h252, 8'h28, "R1 mode reset value");
      wr(16'h252, 8'hFF);
      rd(16'h252, 8'hEB, "R6 reserved bits");
      check("R5 pins all set", {uarta_fast, uartb_fast, uartb_normal, uartb_rx_inv, uartb_tx_inv}, 5'b11111);
      wr(16'h252, 8'h00);
      check("R5 pins clear", {uarta_fast, uartb_fast, uartb_normal, uartb_rx_inv, uartb_tx_inv}, 5'b00000);
      wr(16'h252, 8'h82);
      check("R5 mixed", {uarta_fast, uartb_fast, uartb_normal, uartb_rx_inv, uartb_tx_inv}, 5'b10010);
      wr(16'h252, 8'h00);
      rd(16'h251, 8'h0C, "R12 index read");
      wr(16'h251, 8'hAA);
      check("R7 exit", unlocked, 0);
      wr(16'h252, 8'h77);
      wr(16'h250, 8'h89);
      check("R2 old key dead", unlocked, 0);
      wr(16'h250, 8'h88);
      check("R2 key 0x88", unlocked, 1);
      rd(16'h251, 8'h0C, "R7 index kept");
      rd(16'h252, 8'h00, "R8 locked write ignored");
   endtask

   task automatic t_other_idx;
      wr(16'h251, 8'h20);
      wr(16'h252, 8'h55);
      rd(16'h252, 8'h00, "R10 other index reads 0");
      wr(16'h251, 8'h0C);
      rd(16'h252, 8'h00, "R10 mode untouched");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      bus_addr = 16'h252; bus_wdata = 8'h28; bus_wr = 1'b1; bus_rd = 1'b1;
      #1 check("R11 old value in write cycle", bus_rdata, 8'h00);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      rd(16'h252, 8'h28, "R11 new value next cycle");
   endtask

   task automatic t_high_base;
      wr(16'h251, 8'h16);
      rd(16'h252, 8'h00, "R1 strap value");
      wr(16'h252, 8'h01);
      rd(16'h3F1, 8'h01, "R9 moved data port");
      rd(16'h3F0, 8'h16, "R12 high index read");
      wr(16'h3F0, 8'hAA);
      check("R7 exit high", unlocked, 0);
      wr(16'h250, 8'h89);
      check("R9 old port dead", unlocked, 0);
      wr(16'h3F0, 8'h87);
      check("R3 one write", unlocked, 0);
      wr(16'h3F0, 8'h87);
      check("R3 two writes", unlocked, 1);
      wr(16'h3F0, 8'hAA);
      wr(16'h3F0, 8'h87);
      wr(16'h3F0, 8'h11);
      wr(16'h3F0, 8'h87);
      check("R3 broken pair", unlocked, 0);
      wr(16'h3F0, 8'h87);
      check("R3 pair after break", unlocked, 1);
      wr(16'h3F0, 8'hAA);
      wr(16'h3F0, 8'h87);
      wr(16'h252, 8'h12);
      wr(16'h3F0, 8'h87);
      check("R3 other address ignored", unlocked, 1);
      wr(16'h3F0, 8'h16);
      wr(16'h3F1, 8'h00);
      rd(16'h252, 8'h00, "R4 low data port back");
      wr(16'h251, 8'hAA);
      check("R4 low index port exit", unlocked, 0);
      wr(16'h250, 8'h89);
      check("R9 low key after change", unlocked, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_low_key();
      t_other_idx();
      t_same_cycle();
      t_high_base();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule